// File: doc/BRIEF.md
# Interrupt Distributor Global Register Window

This block holds the small global register window at the front of an interrupt distributor. A 32-bit memory-mapped port with one request per cycle reaches three word registers. The control word holds the distributor's master enable. The capability word reports how many interrupt lines exist and how many processors are currently active. The identity word returns fixed product and implementer codes. No other register is served, and every other offset reads back as zero.

When software writes the control word and moves the master enable from off to on, the block raises a one-cycle wake pulse. This pulse tells the processor interfaces to look again for pending interrupts. A write that leaves the enable unchanged, or that turns it off, produces no pulse. The number of shared interrupt lines is a parameter. The active processor count comes either from a live input or from a parameter, chosen at elaboration.

Top module: `dist_ctrl_window`

## Requirements
- R1: While reset is asserted and directly after it, the enable output, the wake pulse and the read-response valid are all 0.
- R2: A read request is answered exactly one cycle later: rsp_valid is high for that one cycle, with the data. rsp_valid is low in every other cycle, including after writes.
- R3: An access is decoded only when all four byte enables are set, address bits [1:0] are zero and all address bits above bit 3 are zero. Bits [3:2] then select the register: 0 control, 1 capability, 2 identity. Value 3 and every undecoded access read as all zeros.
- R4: A control read returns the stored enable in bit 0 and zeros in bits [31:1].
- R5: Capability bits [4:0] hold (32 + NUM_SHARED)/32 − 1, where the 32 counts the private lines.
- R6: Capability bits [7:5] hold the active processor count minus one, and bits [31:8] are zero. The count is the active_cpus input (1 to MAX_CPUS) when USE_LIVE_CPUS is 1, and NUM_CPUS otherwise.
- R7: An identity read returns PRODUCT_CODE in bits [31:24], IMPLEMENTER_CODE in bits [11:0], and zeros elsewhere.
- R8: A decoded write to the control word loads the enable from wdata bit 0. The new value is visible on dist_enabled in the cycle after the write.
- R9: Writes to the capability word, the identity word, offset 0xC or any address outside the window change neither the enable nor any value read back.
- R10: A write with any byte enable cleared has no effect. A read with any byte enable cleared returns zero, and its response is still given.
- R11: A decoded control write that takes the enable from 0 to 1 raises wake_pulse for exactly the one cycle after the write.
- R12: A control write that keeps the enable unchanged, or clears it, leaves wake_pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe, one request per cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address within the distributor space |
| req_be | input | 4 | Byte enables; only 4'hF is honoured |
| req_wdata | input | 32 | Write data |
| active_cpus | input | 4 | Live count of active processors (1..MAX_CPUS) |
| rsp_valid | output | 1 | Read data valid, one cycle after the read strobe |
| rsp_rdata | output | 32 | Read data, zero when no response is given |
| dist_enabled | output | 1 | Current master enable |
| wake_pulse | output | 1 | One-cycle pulse after an enable rising write |

## Verification
Every result of this block is registered exactly once. Read data and rsp_valid, the updated enable, and the wake pulse are all due in the cycle that follows the request edge. The bench drives each request on a falling edge and removes it on the next falling edge. It compares all outputs at that second falling edge, which is one full register stage later. It then checks once more on the following falling edge that the wake pulse has dropped and that no stray response appears. The sweep covers every byte address from 0x00 to 0x3F under every processor count, plus all partial byte-enable patterns and every combination of prior and written enable value.

// File: rtl/dist_ctrl_pkg.sv
package dist_ctrl_pkg;

   localparam int WORD_W      = 32;
   localparam int BE_W        = WORD_W / 8;
   localparam int CPU_CNT_W   = 4;
   localparam int CPU_FIELD_W = 3;
   localparam int LINE_FIELD_W = 5;
   localparam int PRIV_LINES  = 32;
   localparam int LINES_PER_STEP = 32;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_CAPS  = 2'd1,
      SEL_IDENT = 2'd2,
      SEL_NONE  = 2'd3
   } win_sel_e;

   typedef struct packed {
      logic     rd_strobe;
      logic     wr_ctrl;
      logic     decoded;
      win_sel_e sel;
   } win_req_t;

endpackage

// File: rtl/dist_win_decode.sv
module dist_win_decode
   import dist_ctrl_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [BE_W-1:0]      req_be,
   output win_req_t             dec
);

   localparam int HI_W = ADDR_W - 4;

   logic full_word;
   logic aligned;
   logic in_window;

   assign full_word = (req_be == {BE_W{1'b1}});
   assign aligned   = (req_addr[1:0] == 2'b00);
   assign in_window = (req_addr[ADDR_W-1:4] == {HI_W{1'b0}});

   always_comb begin
      dec           = '0;
      dec.sel       = win_sel_e'(req_addr[3:2]);
      dec.decoded   = full_word && aligned && in_window;
      dec.rd_strobe = req_valid && !req_write;
      dec.wr_ctrl   = req_valid && req_write && dec.decoded && (dec.sel == SEL_CTRL);
   end

endmodule

// File: rtl/dist_enable_reg.sv
module dist_enable_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_ctrl,
   input  logic wr_bit,
   output logic enabled,
   output logic wake
);

   logic rising;

   assign rising = wr_ctrl && !enabled && wr_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enabled <= 1'b0;
         wake    <= 1'b0;
      end else begin
         wake <= rising;
         if (wr_ctrl) begin
            enabled <= wr_bit;
         end
      end
   end

endmodule

// File: rtl/dist_info_words.sv
module dist_info_words
   import dist_ctrl_pkg::*;
#(
   parameter int         NUM_SHARED       = 64,
   parameter int         MAX_CPUS         = 8,
   parameter int         NUM_CPUS         = 4,
   parameter bit         USE_LIVE_CPUS    = 1'b1,
   parameter logic [7:0] PRODUCT_CODE     = 8'h4B,
   parameter logic [11:0] IMPLEMENTER_CODE = 12'h43B
) (
   input  logic [CPU_CNT_W-1:0] active_cpus,
   output logic [WORD_W-1:0]    caps_word,
   output logic [WORD_W-1:0]    ident_word
);

   localparam int TOTAL_LINES = PRIV_LINES + NUM_SHARED;
   localparam int LINE_FIELD  = TOTAL_LINES / LINES_PER_STEP - 1;
   localparam int CAPS_USED   = LINE_FIELD_W + CPU_FIELD_W;
   localparam int IDENT_GAP   = WORD_W - 8 - 12;

   logic [CPU_CNT_W-1:0]   cpus_eff;
   logic [CPU_FIELD_W-1:0] cpu_field;

   if (USE_LIVE_CPUS) begin : g_live_cpus
      assign cpus_eff = active_cpus;
   end else begin : g_fixed_cpus
      logic unused_active_cpus;
      assign unused_active_cpus = ^active_cpus;
      assign cpus_eff = CPU_CNT_W'(NUM_CPUS);
   end

   assign cpu_field = CPU_FIELD_W'(cpus_eff - CPU_CNT_W'(1));

   assign caps_word  = {{(WORD_W-CAPS_USED){1'b0}}, cpu_field, LINE_FIELD_W'(LINE_FIELD)};
   assign ident_word = {PRODUCT_CODE, {IDENT_GAP{1'b0}}, IMPLEMENTER_CODE};

   if (NUM_SHARED % LINES_PER_STEP != 0) begin : g_bad_shared_step
      $error("NUM_SHARED must be a multiple of 32");
   end
   if (LINE_FIELD < 0 || LINE_FIELD >= (1 << LINE_FIELD_W)) begin : g_bad_shared_range
      $error("line count does not fit the capability field");
   end
   if (MAX_CPUS < 1 || MAX_CPUS > (1 << CPU_FIELD_W)) begin : g_bad_max_cpus
      $error("MAX_CPUS must lie in 1..8");
   end
   if (NUM_CPUS < 1 || NUM_CPUS > MAX_CPUS) begin : g_bad_num_cpus
      $error("NUM_CPUS must lie in 1..MAX_CPUS");
   end

endmodule

// File: rtl/dist_rdata_stage.sv
module dist_rdata_stage
   import dist_ctrl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  win_req_t          dec,
   input  logic              enabled,
   input  logic [WORD_W-1:0] caps_word,
   input  logic [WORD_W-1:0] ident_word,
   output logic              rsp_valid,
   output logic [WORD_W-1:0] rsp_rdata
);

   logic [WORD_W-1:0] sel_word;

   always_comb begin
      sel_word = '0;
      if (dec.decoded) begin
         unique case (dec.sel)
            SEL_CTRL:  sel_word = {{(WORD_W-1){1'b0}}, enabled};
            SEL_CAPS:  sel_word = caps_word;
            SEL_IDENT: sel_word = ident_word;
            SEL_NONE:  sel_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= dec.rd_strobe;
         rsp_rdata <= dec.rd_strobe ? sel_word : '0;
      end
   end

endmodule

// File: rtl/dist_ctrl_window.sv
module dist_ctrl_window
   import dist_ctrl_pkg::*;
#(
   parameter int          ADDR_W           = 12,
   parameter int          NUM_SHARED       = 64,
   parameter int          MAX_CPUS         = 8,
   parameter int          NUM_CPUS         = 4,
   parameter bit          USE_LIVE_CPUS    = 1'b1,
   parameter logic [7:0]  PRODUCT_CODE     = 8'h4B,
   parameter logic [11:0] IMPLEMENTER_CODE = 12'h43B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [3:0]        req_be,
   input  logic [31:0]       req_wdata,
   input  logic [3:0]        active_cpus,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   output logic              dist_enabled,
   output logic              wake_pulse
);

   win_req_t          dec;
   logic [WORD_W-1:0] caps_word;
   logic [WORD_W-1:0] ident_word;
   logic              unused_wdata_hi;

   assign unused_wdata_hi = ^req_wdata[WORD_W-1:1];

   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("ADDR_W must be at least 5");
   end

   dist_win_decode #(
      .ADDR_W (ADDR_W)
   ) i_decode (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_be    (req_be),
      .dec       (dec)
   );

   dist_enable_reg i_enable (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (dec.wr_ctrl),
      .wr_bit  (req_wdata[0]),
      .enabled (dist_enabled),
      .wake    (wake_pulse)
   );

   dist_info_words #(
      .NUM_SHARED       (NUM_SHARED),
      .MAX_CPUS         (MAX_CPUS),
      .NUM_CPUS         (NUM_CPUS),
      .USE_LIVE_CPUS    (USE_LIVE_CPUS),
      .PRODUCT_CODE     (PRODUCT_CODE),
      .IMPLEMENTER_CODE (IMPLEMENTER_CODE)
   ) i_info (
      .active_cpus (active_cpus),
      .caps_word   (caps_word),
      .ident_word  (ident_word)
   );

   dist_rdata_stage i_rdata (
      .clk        (clk),
      .rst_n      (rst_n),
      .dec        (dec),
      .enabled    (dist_enabled),
      .caps_word  (caps_word),
      .ident_word (ident_word),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata)
   );

endmodule

// File: rtl/dist_ctrl_window_chk.sv
module dist_ctrl_window_chk #(
   parameter int          ADDR_W       = 12,
   parameter logic [7:0]  PRODUCT_CODE = 8'h4B
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [3:0]        req_be,
   input logic [31:0]       req_wdata,
   input logic              rsp_valid,
   input logic [31:0]       rsp_rdata,
   input logic              dist_enabled,
   input logic              wake_pulse
);

   logic rd_req;
   logic ctrl_wr;
   logic other_or_bad_wr;

   assign rd_req  = req_valid && !req_write;
   assign ctrl_wr = req_valid && req_write && req_be == 4'hF && req_addr == ADDR_W'(0);
   assign other_or_bad_wr = req_valid && req_write && !ctrl_wr;

   AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid);  // R2
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rsp_valid);  // R2
   AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> rsp_rdata == 32'd0);  // R2
   AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && req_addr[3:2] == 2'd3 |=> rsp_rdata == 32'd0);  // R3
   AST_PARTIAL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && req_be != 4'hF |=> rsp_rdata == 32'd0);  // R10
   AST_IDENT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && req_be == 4'hF && req_addr == ADDR_W'(8) |=> rsp_rdata[31:24] == PRODUCT_CODE);  // R7
   AST_CTRL_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> dist_enabled == $past(req_wdata[0]));  // R8
   AST_OTHER_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      other_or_bad_wr |=> $stable(dist_enabled));  // R9
   AST_READ_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid || !req_write |=> $stable(dist_enabled));  // R9
   AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dist_enabled) |-> wake_pulse);  // R11
   AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);  // R11
   AST_WAKE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> dist_enabled && !$past(dist_enabled));  // R12

endmodule

bind dist_ctrl_window dist_ctrl_window_chk #(
   .ADDR_W       (ADDR_W),
   .PRODUCT_CODE (PRODUCT_CODE)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_write    (req_write),
   .req_addr     (req_addr),
   .req_be       (req_be),
   .req_wdata    (req_wdata),
   .rsp_valid    (rsp_valid),
   .rsp_rdata    (rsp_rdata),
   .dist_enabled (dist_enabled),
   .wake_pulse   (wake_pulse)
);

// File: tb/test_dist_ctrl_window.sv
module test_dist_ctrl_window;

   localparam int          ADDR_W     = 12;
   localparam int          NUM_SHARED = 64;
   localparam logic [7:0]  PROD       = 8'h4B;
   localparam logic [11:0] IMPL       = 12'h43B;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [3:0]        req_be = 4'h0;
   logic [31:0]       req_wdata = '0;
   logic [3:0]        active_cpus = 4'd4;
   logic              rsp_valid;
   logic [31:0]       rsp_rdata;
   logic              dist_enabled;
   logic              wake_pulse;

   int n_vec  = 0;
   int n_fail = 0;
   logic en_m = 1'b0;

   always #10 clk = ~clk;

   dist_ctrl_window i_dist_ctrl_window (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_write    (req_write),
      .req_addr     (req_addr),
      .req_be       (req_be),
      .req_wdata    (req_wdata),
      .active_cpus  (active_cpus),
      .rsp_valid    (rsp_valid),
      .rsp_rdata    (rsp_rdata),
      .dist_enabled (dist_enabled),
      .wake_pulse   (wake_pulse)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic decoded(input logic [ADDR_W-1:0] a, input logic [3:0] be);
      return be == 4'hF && a[1:0] == 2'b00 && a[ADDR_W-1:4] == '0;
   endfunction

   function automatic logic [31:0] exp_word(input logic [ADDR_W-1:0] a, input logic [3:0] be,
                                            input logic en, input int cpus);
      logic [31:0] w;
      w = '0;
      if (decoded(a, be)) begin
         case (a[3:2])
            2'd0: w = {31'd0, en};
            2'd1: w = 32'((32 + NUM_SHARED) / 32 - 1) | (32'(cpus - 1) << 5);
            2'd2: w = {PROD, 12'd0, IMPL};
            default: w = '0;
         endcase
      end
      return w;
   endfunction

   task automatic do_read(input logic [ADDR_W-1:0] a, input logic [3:0] be, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
      chk(req, rsp_rdata, exp_word(a, be, en_m, int'(active_cpus)));
   endtask

   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [3:0] be,
                           input logic [31:0] d, input string req);
      logic exp_wake;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      exp_wake = 1'b0;
      if (decoded(a, be) && a[3:2] == 2'd0) begin
         exp_wake = !en_m && d[0];
         en_m = d[0];
      end
      chk({req, " wake"}, {31'd0, wake_pulse}, {31'd0, exp_wake});
      chk({req, " enable"}, {31'd0, dist_enabled}, {31'd0, en_m});
      chk("R2 no rsp after write", {31'd0, rsp_valid}, 32'd0);
      @(negedge clk);
      chk("R11 wake single cycle", {31'd0, wake_pulse}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset enable", {31'd0, dist_enabled}, 32'd0);
      chk("R1 reset wake", {31'd0, wake_pulse}, 32'd0);
      chk("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset enable", {31'd0, dist_enabled}, 32'd0);

      // R3 R4 R5 R6 R7: full address sweep under every processor count
      for (int c = 1; c <= 8; c++) begin
         active_cpus = 4'(c);
         for (int a = 0; a < 64; a++) begin
            do_read(ADDR_W'(a), 4'hF, "R3 R5 R6 R7 window sweep");
         end
      end
      active_cpus = 4'd2;
      do_read(ADDR_W'(12'h100), 4'hF, "R3 high address reads zero");
      do_read(ADDR_W'(12'hFF4), 4'hF, "R3 high address reads zero");
      do_read(ADDR_W'(12'h014), 4'hF, "R3 next window reads zero");

      // R8 R11 R12: every prior state against every written bit, upper bits varied
      for (int p = 0; p < 2; p++) begin
         for (int w = 0; w < 2; w++) begin
            for (int u = 0; u < 3; u++) begin
               logic [31:0] hi;
               hi = (u == 0) ? 32'd0 : ((u == 1) ? 32'hFFFF_FFFE : 32'h5A5A_A5A4);
               do_write(ADDR_W'(0), 4'hF, hi | 32'(p), "R8 R11 R12 set prior");
               do_write(ADDR_W'(0), 4'hF, hi | 32'(w), "R8 R11 R12 transition");
               do_read(ADDR_W'(0), 4'hF, "R4 control readback");
            end
         end
      end

      // R9: writes elsewhere never touch enable or the read-only words
      do_write(ADDR_W'(0), 4'hF, 32'd0, "R8 clear");
      do_write(ADDR_W'(4), 4'hF, 32'hFFFF_FFFF, "R9 caps write ignored");
      do_write(ADDR_W'(8), 4'hF, 32'hFFFF_FFFF, "R9 ident write ignored");
      do_write(ADDR_W'(12), 4'hF, 32'hFFFF_FFFF, "R9 hole write ignored");
      do_write(ADDR_W'(12'h100), 4'hF, 32'd1, "R9 out of window write ignored");
      do_write(ADDR_W'(1), 4'hF, 32'd1, "R9 misaligned write ignored");
      for (int a = 0; a < 16; a += 4) begin
         do_read(ADDR_W'(a), 4'hF, "R9 words unchanged");
      end

      // R10: partial byte enables
      for (int be = 0; be < 15; be++) begin
         do_write(ADDR_W'(0), 4'(be), 32'd1, "R10 partial write ignored");
         do_read(ADDR_W'(0), 4'(be), "R10 partial read zero");
         do_read(ADDR_W'(8), 4'(be), "R10 partial read zero");
      end
      do_read(ADDR_W'(0), 4'hF, "R10 enable still clear");

      // R11 then R12: enable, re-enable, disable
      do_write(ADDR_W'(0), 4'hF, 32'd1, "R11 rise");
      do_write(ADDR_W'(0), 4'hF, 32'd1, "R12 keep");
      do_write(ADDR_W'(0), 4'hF, 32'd0, "R12 clear");
      do_write(ADDR_W'(0), 4'hF, 32'd1, "R11 rise again");
      do_read(ADDR_W'(0), 4'hF, "R4 enabled readback");

      @(negedge clk);
      chk("R2 idle no rsp", {31'd0, rsp_valid}, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule